// File: doc/BRIEF.md
# Tuner Synthesiser Serial Control Slave

This block is the serial-bus slave that holds every programmable setting of a tuner frequency synthesiser. A host writes a 15-bit division ratio, a control byte and an output-port byte over a two-wire I2C bus. It reads back a status byte that reports a power-up flag, the loop lock flag, three digital port levels and a 3-bit converter code. The bus lines are sampled on the system clock. The open-drain data line is modelled as a drive-low enable.

After a matching address, each written byte steers itself. If its top bit is 0, it is the upper part of the division ratio and the next byte completes the ratio. If its top bit is 1, it is the control byte and the next byte sets the ports. Byte pairs can keep streaming until a stop condition, which allows continuous frequency sweeps. A byte cut short by a stop or start condition is discarded. In read mode the status byte repeats for as long as the host acknowledges. The power-up flag is cleared by the stop that ends a read.

Top module: `tuner_synth_ctl`

## Requirements
- R1: The slave acknowledges an address byte of the form 1,1,0,0,0,S1,S0,RW (MSB first) when S1:S0 is 00, or when S1:S0 equals `alt_sub_i`. It acknowledges by driving SDA low during the ninth clock, and it releases SDA after any start condition.
- R2: For any other address byte the slave never drives SDA, and no register changes until the next start condition.
- R3: A written byte with MSB 0 stages ratio bits 14..8 from its bits 6..0. The next byte supplies ratio bits 7..0. `ratio_o` updates only when that second byte completes.
- R4: A written byte with MSB 1 sets CP from bit 6, T1 from bit 5, T0 from bit 4 and OS from bit 0.
- R5: The byte that follows a control byte drives `port_o`. Bits 7..3 and bit 0 are copied, and bits 2..1 always read 0.
- R6: Every data byte in a write is acknowledged. Pairs may repeat without a new address, and steering restarts after each completed pair.
- R7: A byte interrupted by a stop condition before its eighth bit leaves every register unchanged.
- R8: The status byte is sent MSB first as POR, lock, port_in[2:0], adc[2:0]. SDA changes only while SCL is low.
- R9: When the host acknowledges, another status byte follows. When the host does not acknowledge, the slave releases SDA.
- R10: POR is cleared only by a stop that ends a read transfer. A write transfer leaves it set.
- R11: After reset the ratio, control bits and ports are 0, POR reads as 1, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low_o | output | 1 | Pull the data line low when 1 |
| alt_sub_i | input | 2 | Second accepted sub-address, from an external level detector |
| lock_i | input | 1 | Loop lock flag for the status byte |
| port_in_i | input | 3 | Digital port levels for the status byte |
| adc_code_i | input | 3 | Converter code for the status byte |
| ratio_o | output | 15 | Committed division ratio |
| cp_o | output | 1 | Charge-pump current select |
| t1_o | output | 1 | Comparator test routing select |
| t0_o | output | 1 | Charge-pump disable |
| os_o | output | 1 | Drive amplifier disable |
| port_o | output | 8 | Output port enables, bits 2..1 fixed at 0 |

## Verification
The bench targets the corners listed here and the failure each one exposes.

- A lone upper divider byte closed by a stop. A design that committed the ratio early would show a half-updated ratio.
- A stop in the middle of a byte. A design that committed partial bytes would corrupt a register.
- Addresses with a rejected sub-address or a wrong device prefix. Loose matching would acknowledge these and commit the data that follows.
- POR read after a write transfer and again after a read transfer. Clearing on the wrong stop would show up here.
- Multi-byte reads with host acknowledge and host no-acknowledge. A slave that missed the host acknowledge would stop sending or hold the line.
- Random streams of mixed byte pairs, checked against a bench model.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_state_e;

    // what the next completed write byte means
    typedef enum logic [1:0] {
        NX_STEER,
        NX_DIV_LO,
        NX_PORT
    } next_byte_e;

    localparam logic [4:0] DEV_PREFIX = 5'b11000;
    localparam logic [7:0] PORT_MASK  = 8'b1111_1001;

    function automatic logic addr_hit(input logic [7:0] a, input logic [1:0] alt);
        logic [1:0] sub;
        sub = a[2:1];
        return (a[7:3] == DEV_PREFIX) && ((sub == 2'b00) || (sub == alt));
    endfunction

endpackage

// File: rtl/tsyn_sync.sv
module tsyn_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= async_d;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign sync_q = pipe_q[STAGES-1];
endmodule

// File: rtl/tsyn_bus_cond.sv
module tsyn_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_det = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_det  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
endmodule

// File: rtl/tuner_synth_ctl.sv
module tuner_synth_ctl
    import tsyn_pkg::*;
#(
    parameter int RATIO_W     = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_drive_low_o,
    input  logic [1:0]         alt_sub_i,
    input  logic               lock_i,
    input  logic [2:0]         port_in_i,
    input  logic [2:0]         adc_code_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cp_o,
    output logic               t1_o,
    output logic               t0_o,
    output logic               os_o,
    output logic [7:0]         port_o
);
    localparam int HI_W = RATIO_W - 8;

    typedef struct packed {
        bus_state_e         st;
        logic [2:0]         cnt;
        logic               got8;
        logic [7:0]         sh;
        logic [7:0]         tx;
        logic               drv;
        logic               rw;
        logic               rd_sess;
        logic               mack;
        next_byte_e         nx;
        logic [HI_W-1:0]    hi_stage;
        logic [RATIO_W-1:0] ratio;
        logic               cp;
        logic               t1;
        logic               t0;
        logic               os;
        logic [7:0]         port;
        logic               por;
    } ctl_t;

    logic [1:0] lines_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic por_flag;
    logic [7:0] byte_in;
    logic [7:0] status;

    ctl_t q, d;

    tsyn_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d ({scl_i, sda_i}),
        .sync_q  (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    tsyn_bus_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_in = {q.sh[6:0], sda_s};
    assign status  = {q.por, lock_i, port_in_i, adc_code_i};

    always_comb begin
        d = q;
        if (stop_det) begin
            d.st   = ST_IDLE;
            d.drv  = 1'b0;
            d.got8 = 1'b0;
            if (q.rd_sess) d.por = 1'b0;
            d.rd_sess = 1'b0;
        end else if (start_det) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.got8 = 1'b0;
            d.drv  = 1'b0;
            d.nx   = NX_STEER;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.got8 = 1'b1;
                    end else if (scl_fall && q.got8) begin
                        d.got8 = 1'b0;
                        if (addr_hit(q.sh, alt_sub_i)) begin
                            d.drv = 1'b1;
                            d.rw  = q.sh[0];
                            d.st  = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.tx      = status;
                            d.drv     = ~status[7];
                            d.st      = ST_RD;
                            d.rd_sess = 1'b1;
                        end else begin
                            d.drv = 1'b0;
                            d.st  = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            d.got8 = 1'b1;
                            unique case (q.nx)
                                NX_DIV_LO: begin
                                    d.ratio = {q.hi_stage, byte_in};
                                    d.nx    = NX_STEER;
                                end
                                NX_PORT: begin
                                    d.port = byte_in & PORT_MASK;
                                    d.nx   = NX_STEER;
                                end
                                default: begin
                                    if (!byte_in[7]) begin
                                        d.hi_stage = byte_in[HI_W-1:0];
                                        d.nx       = NX_DIV_LO;
                                    end else begin
                                        d.cp = byte_in[6];
                                        d.t1 = byte_in[5];
                                        d.t0 = byte_in[4];
                                        d.os = byte_in[0];
                                        d.nx = NX_PORT;
                                    end
                                end
                            endcase
                        end
                    end else if (scl_fall && q.got8) begin
                        d.got8 = 1'b0;
                        d.drv  = 1'b1;
                        d.st   = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.drv = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.got8 = 1'b1;
                    end else if (scl_fall) begin
                        if (q.got8) begin
                            d.got8 = 1'b0;
                            d.drv  = 1'b0;
                            d.st   = ST_RD_ACK;
                        end else begin
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.drv = ~q.tx[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.tx  = status;
                            d.drv = ~status[7];
                            d.cnt = '0;
                            d.st  = ST_RD;
                        end else begin
                            d.drv = 1'b0;
                            d.st  = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.nx  <= NX_STEER;
            q.por <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_low_o = q.drv;
    assign ratio_o         = q.ratio;
    assign cp_o            = q.cp;
    assign t1_o            = q.t1;
    assign t0_o            = q.t0;
    assign os_o            = q.os;
    assign port_o          = q.port;
    assign por_flag        = q.por;
endmodule

// File: rtl/tsyn_checker.sv
module tsyn_checker #(
    parameter int RATIO_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_rise,
    input logic               scl_fall,
    input logic               start_det,
    input logic               stop_det,
    input logic               sda_drive_low_o,
    input logic [RATIO_W-1:0] ratio_o,
    input logic               cp_o,
    input logic               t1_o,
    input logic               t0_o,
    input logic               os_o,
    input logic [7:0]         port_o,
    input logic               por_flag
);
    assert_ratio_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_o) |-> $past(scl_rise));

    assert_ctrl_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cp_o, t1_o, t0_o, os_o}) |-> $past(scl_rise));

    assert_port_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_o) |-> $past(scl_rise));

    assert_sda_low_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> $past(scl_fall || start_det || stop_det));

    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_drive_low_o);

    assert_por_clear_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(stop_det));

    assert_por_never_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(por_flag));
endmodule

bind tuner_synth_ctl tsyn_checker #(.RATIO_W(RATIO_W)) i_tsyn_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_rise        (scl_rise),
    .scl_fall        (scl_fall),
    .start_det       (start_det),
    .stop_det        (stop_det),
    .sda_drive_low_o (sda_drive_low_o),
    .ratio_o         (ratio_o),
    .cp_o            (cp_o),
    .t1_o            (t1_o),
    .t0_o            (t0_o),
    .os_o            (os_o),
    .port_o          (port_o),
    .por_flag        (por_flag)
);

// File: tb/test_tuner_synth_ctl.sv
module test_tuner_synth_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_drive_low_o;
    logic [1:0] alt_sub_i = 2'b10;
    logic lock_i = 1'b0;
    logic [2:0] port_in_i = 3'd0;
    logic [2:0] adc_code_i = 3'd0;
    logic [14:0] ratio_o;
    logic cp_o, t1_o, t0_o, os_o;
    logic [7:0] port_o;

    int checks = 0;
    int errors = 0;

    logic [14:0] e_ratio = '0;
    logic [6:0]  e_hi = '0;
    logic [3:0]  e_ctl = '0;
    logic [7:0]  e_port = '0;
    logic        e_por = 1'b1;
    int          e_nx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low_o;

    tuner_synth_ctl i_tuner_synth_ctl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_drive_low_o(sda_drive_low_o), .alt_sub_i(alt_sub_i),
        .lock_i(lock_i), .port_in_i(port_in_i), .adc_code_i(adc_code_i),
        .ratio_o(ratio_o), .cp_o(cp_o), .t1_o(t1_o), .t0_o(t0_o),
        .os_o(os_o), .port_o(port_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(PH); scl_m = 1'b1; wt(PH);
        sda_m = 1'b0; wt(PH); scl_m = 1'b0; wt(PH);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(PH); scl_m = 1'b1; wt(PH);
        sda_m = 1'b1; wt(PH);
    endtask

    task automatic clk_bit(input logic b);
        sda_m = b; wt(PH); scl_m = 1'b1; wt(PH); scl_m = 1'b0; wt(PH);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1'b1; wt(PH); scl_m = 1'b1; wt(PH/2);
        ack = ~sda_line; wt(PH/2); scl_m = 1'b0; wt(PH);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(PH); scl_m = 1'b1; wt(PH/2); b[i] = sda_line;
            wt(PH/2); scl_m = 1'b0;
        end
        wt(PH/2); sda_m = ~mack; wt(PH/2);
        scl_m = 1'b1; wt(PH); scl_m = 1'b0; wt(PH/2); sda_m = 1'b1; wt(PH/2);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] sub, input logic rd);
        return {5'b11000, sub, rd};
    endfunction

    function automatic logic accepted(input logic [1:0] sub);
        return (sub == 2'b00) || (sub == alt_sub_i);
    endfunction

    task automatic model_byte(input logic [7:0] b);
        if (e_nx == 1) begin e_ratio = {e_hi, b}; e_nx = 0; end
        else if (e_nx == 2) begin e_port = b & 8'hF9; e_nx = 0; end
        else if (!b[7]) begin e_hi = b[6:0]; e_nx = 1; end
        else begin e_ctl = {b[6], b[5], b[4], b[0]}; e_nx = 2; end
    endtask

    task automatic check_regs(input string req);
        chk(req, ratio_o, e_ratio);
        chk(req, {cp_o, t1_o, t0_o, os_o}, e_ctl);
        chk(req, port_o, e_port);
    endtask

    task automatic write_two(input logic [1:0] sub, input logic [7:0] b0, input logic [7:0] b1);
        logic ack;
        i2c_start(); e_nx = 0;
        send_byte(addr_byte(sub, 1'b0), ack);
        chk("R1 address ack", ack, 1'b1);
        send_byte(b0, ack); chk("R6 data ack", ack, 1'b1); model_byte(b0);
        send_byte(b1, ack); chk("R6 data ack", ack, 1'b1); model_byte(b1);
        i2c_stop();
    endtask

    task automatic read_status(input int nbytes);
        logic ack;
        logic [7:0] b;
        i2c_start();
        send_byte(addr_byte(2'b00, 1'b1), ack);
        chk("R1 read address ack", ack, 1'b1);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k != nbytes - 1, b);
            chk("R8 status byte", b, {e_por, lock_i, port_in_i, adc_code_i});
        end
        chk("R9 released after nack", sda_drive_low_o, 1'b0);
        i2c_stop();
        e_por = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        void'($urandom(32'h1F2E3D));
        wt(5); rst_n = 1'b1; wt(5);

        // R11 reset state
        check_regs("R11 reset");
        chk("R11 sda released", sda_drive_low_o, 1'b0);

        // R3 / R10: write a ratio, POR must survive a write transfer
        write_two(2'b00, 8'h35, 8'hA7);
        check_regs("R3 divider pair");
        lock_i = 1'b1; port_in_i = 3'b101; adc_code_i = 3'b011;
        read_status(2);   // R9 host ack gives second byte, R10 POR still 1 here
        lock_i = 1'b0; port_in_i = 3'b010; adc_code_i = 3'b100;
        read_status(1);   // R10 POR now cleared

        // R3: upper byte alone never reaches the ratio
        i2c_start(); e_nx = 0;
        send_byte(addr_byte(2'b10, 1'b0), ack); chk("R1 alt sub ack", ack, 1'b1);
        send_byte(8'h12, ack); chk("R6 data ack", ack, 1'b1);
        i2c_stop();
        check_regs("R3 lone upper byte");

        // R4 R5 control and port byte, alternate sub-address
        write_two(2'b10, 8'hDF, 8'hFF);
        check_regs("R4 R5 control and port");
        write_two(2'b00, 8'b1010_1110, 8'b0100_0111);
        check_regs("R4 R5 second pattern");

        // R6 stream without re-address
        i2c_start(); e_nx = 0;
        send_byte(addr_byte(2'b00, 1'b0), ack); chk("R1 address ack", ack, 1'b1);
        foreach (b[i]) ;
        begin
            logic [7:0] seq [6];
            seq = '{8'h01, 8'h02, 8'h7F, 8'hFE, 8'h80, 8'h09};
            for (int k = 0; k < 6; k++) begin
                send_byte(seq[k], ack); chk("R6 stream ack", ack, 1'b1); model_byte(seq[k]);
            end
        end
        i2c_stop();
        check_regs("R6 stream result");

        // R7 abort in the middle of a low divider byte and a control byte
        i2c_start(); e_nx = 0;
        send_byte(addr_byte(2'b00, 1'b0), ack);
        send_byte(8'h44, ack);
        for (int i = 0; i < 5; i++) clk_bit(1'b1);
        i2c_stop();
        check_regs("R7 abort in low byte");
        i2c_start(); e_nx = 0;
        send_byte(addr_byte(2'b00, 1'b0), ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b1);
        i2c_stop();
        check_regs("R7 abort in first byte");

        // R2 rejected sub-address and wrong prefix
        i2c_start();
        send_byte(addr_byte(2'b01, 1'b0), ack); chk("R2 no ack sub 01", ack, 1'b0);
        send_byte(8'h80, ack); chk("R2 no ack data", ack, 1'b0);
        send_byte(8'hF9, ack);
        i2c_stop();
        check_regs("R2 rejected write");
        i2c_start();
        send_byte(8'b1101_0000, ack); chk("R2 no ack bad prefix", ack, 1'b0);
        i2c_stop();

        // random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            logic [1:0] sub;
            op = $urandom_range(0, 3);
            sub = 2'($urandom_range(0, 3));
            if (op == 0) begin
                lock_i = 1'($urandom); port_in_i = 3'($urandom); adc_code_i = 3'($urandom);
                read_status($urandom_range(1, 3));
            end else begin
                logic [7:0] b0, b1;
                b0 = 8'($urandom); b1 = 8'($urandom);
                if (op == 1) b0[7] = 1'b0;
                if (op == 2) b0[7] = 1'b1;
                if (accepted(sub)) begin
                    write_two(sub, b0, b1);
                end else begin
                    i2c_start();
                    send_byte(addr_byte(sub, 1'b0), ack); chk("R2 random reject", ack, 1'b0);
                    send_byte(b0, ack); send_byte(b1, ack);
                    i2c_stop();
                end
                check_regs("R3 R4 R5 random write");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule